// File: doc/BRIEF.md
# GPIO Output Latch Port with Atomic Set/Clear/Toggle

This block is a 32-bit general-purpose output port on a simple synchronous register bus. Each implemented pin owns an output data latch and a direction bit. Software can write the latch image directly through a data register. It can also change individual pins without a read-modify-write, through three write-one alias registers that set, clear or invert the bits marked with a 1.

The latch is stored whatever the pin's direction. The direction bit only decides whether the pad is driven: the pad output enable follows the direction bit, and the pad value is the latch gated by that enable. Only bit positions 26 down to 18 and 12 down to 0 hold storage. Every other position is reserved: it reads as 0, never stores and never drives.

Register word addresses on `addr_i`: 0 is the data register, 1 is the set alias, 2 is the clear alias, 3 is the toggle alias, 4 is the direction register, and 5 to 7 are unmapped. The bus carries one access per cycle.

Top module: `gpo_latch_port`

## Requirements
- R1: After reset, every latch bit and direction bit is 0, so `pad_o`, `oe_o` and the readback of the data (address 0) and direction (address 4) registers are all zero.
- R2: A write to address 0 loads the implemented latch bits from `wdata_i`. A read of address 0 returns the latch value.
- R3: A write to the set alias (address 1) forces high each latch bit whose `wdata_i` bit is 1 and leaves bits written with 0 unchanged.
- R4: A write to the clear alias (address 2) forces low each latch bit whose `wdata_i` bit is 1 and leaves bits written with 0 unchanged.
- R5: A write to the toggle alias (address 3) inverts each latch bit whose `wdata_i` bit is 1 and leaves bits written with 0 unchanged.
- R6: Reads of the set, clear and toggle aliases (addresses 1, 2 and 3) always return 0, whatever the latch holds.
- R7: Bits 31 to 27 and 17 to 13 are reserved. Writes to them are discarded, and they read as 0 at every address and are 0 on `pad_o` and `oe_o`.
- R8: The latch is updated by any write even when its pin is an input. `oe_o` equals the direction bits, and `pad_o` equals the latch AND the direction bits.
- R9: A write to address 4 loads the direction bits (1 = output, 0 = input). A read of address 4 returns them.
- R10: A write takes effect on the clock edge that samples it. `pad_o`, `oe_o` and the readback keep their old value before that edge and show the new value after it.
- R11: With `we_i` low, or when the address is unmapped (5 to 7), the latch and direction bits do not change, and reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pad_o | output | 32 | Pad output values |
| oe_o | output | 32 | Pad output enables |

## Verification
The assertions check on every cycle that reserved positions never appear on readback or enables, and that no pad is high without its enable. They also check that alias reads return zero, and that each alias write leaves the latch set, cleared or inverted exactly under the written mask. Idle or unmapped cycles must leave the state unchanged. Only the bench scenarios can show how writes interact over a history: a value stored while a pin is an input and revealed later when the direction flips, the exact edge at which the pads change, and readback agreeing with a reference model through long random mixes of all five registers.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TGL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd4;

  typedef struct packed {
    logic data_we;
    logic set_we;
    logic clr_we;
    logic tgl_we;
    logic dir_we;
  } gpo_wr_t;
endpackage

// File: rtl/gpo_decode.sv
module gpo_decode
  import gpo_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output gpo_wr_t           wr_o
);
  always_comb begin
    wr_o = '0;
    if (we_i) begin
      unique case (addr_i)
        A_DATA:  wr_o.data_we = 1'b1;
        A_SET:   wr_o.set_we  = 1'b1;
        A_CLR:   wr_o.clr_we  = 1'b1;
        A_TGL:   wr_o.tgl_we  = 1'b1;
        A_DIR:   wr_o.dir_we  = 1'b1;
        default: wr_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpo_bit_cell.sv
module gpo_bit_cell
  import gpo_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  gpo_wr_t wr_i,
  input  logic    wbit_i,
  output logic    lat_o,
  output logic    dir_o
);
  logic lat_q, dir_q;

  // priority: direct data, clear, set, toggle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= 1'b0;
    end else if (wr_i.data_we) begin
      lat_q <= wbit_i;
    end else if (wr_i.clr_we && wbit_i) begin
      lat_q <= 1'b0;
    end else if (wr_i.set_we && wbit_i) begin
      lat_q <= 1'b1;
    end else if (wr_i.tgl_we && wbit_i) begin
      lat_q <= ~lat_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           dir_q <= 1'b0;
    else if (wr_i.dir_we)  dir_q <= wbit_i;
  end

  assign lat_o = lat_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/gpo_read_mux.sv
module gpo_read_mux
  import gpo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] lat_i,
  input  logic [DATA_W-1:0] dir_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      A_DATA:  rdata_o = lat_i;
      A_DIR:   rdata_o = dir_i;
      default: rdata_o = '0;  // aliases and unmapped read zero
    endcase
  end
endmodule

// File: rtl/gpo_latch_port.sv
module gpo_latch_port
  import gpo_pkg::*;
#(
  parameter int unsigned        DATA_W    = 32,
  parameter logic [DATA_W-1:0]  IMPL_MASK = 32'h07FC_1FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] oe_o
);
  gpo_wr_t           wr;
  logic [DATA_W-1:0] wdata_m;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] dir_q;

  // reserved positions never see a 1, so their cells stay at reset value
  assign wdata_m = wdata_i & IMPL_MASK;

  gpo_decode u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .wr_o   (wr)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    gpo_bit_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr),
      .wbit_i (wdata_m[i]),
      .lat_o  (latch_q[i]),
      .dir_o  (dir_q[i])
    );
  end

  gpo_read_mux #(.DATA_W(DATA_W)) u_rd (
    .addr_i  (addr_i),
    .lat_i   (latch_q),
    .dir_i   (dir_q),
    .rdata_o (rdata_o)
  );

  assign oe_o  = dir_q;
  assign pad_o = latch_q & dir_q;
endmodule

// File: rtl/gpo_latch_port_chk.sv
module gpo_latch_port_chk
  import gpo_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h07FC_1FFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] pad_o,
  input logic [DATA_W-1:0] oe_o,
  input logic [DATA_W-1:0] latch_q,
  input logic [DATA_W-1:0] dir_q
);
  logic [DATA_W-1:0] wm;
  logic              alias_a, mapped_a;
  assign wm       = wdata_i & IMPL_MASK;
  assign alias_a  = (addr_i == A_SET) || (addr_i == A_CLR) || (addr_i == A_TGL);
  assign mapped_a = alias_a || (addr_i == A_DATA) || (addr_i == A_DIR);

  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o | oe_o | pad_o) & ~IMPL_MASK) == '0);  // R7

  AST_PAD_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & ~oe_o) == '0);  // R8

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_a |-> rdata_o == '0);  // R6

  AST_SET_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET) |=>
      latch_q == ($past(latch_q) | $past(wm)));  // R3

  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR) |=>
      latch_q == ($past(latch_q) & ~$past(wm)));  // R4

  AST_TGL_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_TGL) |=>
      latch_q == ($past(latch_q) ^ $past(wm)));  // R5

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || !mapped_a) |=> ($stable(latch_q) && $stable(dir_q)));  // R11
endmodule

bind gpo_latch_port gpo_latch_port_chk #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .oe_o    (oe_o),
  .latch_q (latch_q),
  .dir_q   (dir_q)
);

// File: tb/gpo_latch_port_test.sv
`timescale 1ns/1ps
module gpo_latch_port_test;
  localparam logic [31:0] MASK = 32'h07FC_1FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad, oe;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_lat = '0;
  logic [31:0] m_dir = '0;

  always #10 clk = ~clk;

  gpo_latch_port uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pad_o(pad), .oe_o(oe)
  );

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:    return m_lat;
      3'd4:    return m_dir;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] a, input logic w, input logic [31:0] d);
    logic [31:0] dm = d & MASK;
    if (w) case (a)
      3'd0: m_lat = dm;
      3'd1: m_lat = m_lat | dm;
      3'd2: m_lat = m_lat & ~dm;
      3'd3: m_lat = m_lat ^ dm;
      3'd4: m_dir = dm;
      default: ;
    endcase
  endtask

  task automatic check_pads(input string req);
    check({req, " oe"},  oe,  m_dir);
    check({req, " pad"}, pad, m_lat & m_dir);
  endtask

  // drive at negedge, sample at next negedge
  task automatic access(input logic [2:0] a, input logic w, input logic [31:0] d, input string req);
    @(negedge clk);
    addr = a; we = w; wdata = d;
    #1;
    check({req, " R10 pad before edge"}, pad, m_lat & m_dir);
    @(negedge clk);
    we = 1'b0;
    model(a, w, d);
    check_pads(req);
  endtask

  task automatic read(input logic [2:0] a, input string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    check(req, rdata, exp_rd(a));
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #35 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 pad", pad, '0);
    check("R1 oe", oe, '0);
    read(3'd0, "R1 data");
    read(3'd4, "R1 dir");

    // R2 direct data write with reserved bits (R7)
    access(3'd0, 1'b1, 32'hFFFF_FFFF, "R2 data all ones");
    read(3'd0, "R2/R7 data readback");
    check("R7 reserved masked", rdata & ~MASK, '0);

    // R8 latch kept while input, revealed when output
    access(3'd0, 1'b1, 32'h0, "R2 data clear");
    access(3'd1, 1'b1, 32'h0004_0001, "R8 set on input pins");
    check("R8 pad undriven", pad, '0);
    read(3'd0, "R8 latch stored");
    access(3'd4, 1'b1, 32'hFFFF_FFFF, "R9 dir all out");
    check("R8 pad revealed", pad, 32'h0004_0001);
    read(3'd4, "R9/R7 dir readback");

    // R3 zeros leave bits alone; R4, R5
    access(3'd1, 1'b1, 32'h0000_0F00, "R3 set");
    access(3'd1, 1'b1, 32'h0, "R3 set zero no effect");
    access(3'd2, 1'b1, 32'h0000_0300, "R4 clear");
    access(3'd2, 1'b1, 32'h0, "R4 clear zero no effect");
    access(3'd3, 1'b1, 32'h07FC_1FFF, "R5 toggle all");
    access(3'd3, 1'b1, 32'hF803_E000, "R5/R7 toggle reserved only");

    // R6 alias reads zero while latch nonzero
    read(3'd1, "R6 set reads 0");
    read(3'd2, "R6 clear reads 0");
    read(3'd3, "R6 toggle reads 0");

    // R11 unmapped writes and idle cycles
    access(3'd5, 1'b1, 32'hFFFF_FFFF, "R11 unmapped write");
    access(3'd0, 1'b0, 32'h0, "R11 we low");
    read(3'd6, "R11 unmapped read");
    read(3'd0, "R11 latch unchanged");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  a = 3'($urandom_range(0, 7));
      logic        w = ($urandom_range(0, 3) != 0);
      logic [31:0] d = $urandom();
      access(a, w, d, "R2-mix random access");
      read(3'($urandom_range(0, 7)), "R2 R9 random readback");
    end

    // reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    m_lat = '0; m_dir = '0;
    #1;
    check_pads("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    read(3'd0, "R1 data after reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule